// File: doc/BRIEF.md
# Timer Capture Input Conditioning Channel

This block is the input side of one timer channel. Three external channel pins are synchronized into the clock domain. The channel input is either the channel's own pin or the exclusive-OR of all three pins, which suits hall-sensor style commutation inputs. From that input, from the neighbouring channel's pin, or from a one-cycle event pulse supplied by a trigger controller, a mode field picks the capture signal. Rising edges of the capture signal, or trigger pulses, are active events.

A prescaler lets only every 1st, 2nd, 4th or 8th active event through. Each event that passes copies the free-running counter value into a capture register and raises a capture flag. If the flag is already set, an overcapture flag is raised as well. A small word-addressed register interface holds the configuration, the channel enable and the write-one-to-clear status. The interface blocks changes to the mode field while the channel is enabled.

Top module: `tcf_top`

## Requirements
- R1: After reset, every register reads zero: configuration (address 0), control (address 1), status (address 2) and capture (address 3).
- R2: In the configuration word, bit 31 is the source select, bits 19:18 are the prescaler code, bits 17:16 are the mode code and bits 3:0 are a stored filter field. Writing all ones while disabled reads back 0x800F000F, so every other bit reads zero.
- R3: While the enable (control bit 0) is 1, a configuration write leaves the mode code unchanged and still updates the source, prescaler and filter fields. While the enable is 0, the mode code is written.
- R4: With source select 0 and mode 01, a rising edge on pin 0 captures the counter. Edges on pins 1 and 2, and falling edges on pin 0, capture nothing.
- R5: With source select 1 and mode 01, the channel input is pin0^pin1^pin2, and each rising edge of that XOR captures the counter.
- R6: With mode 10, a rising edge on pin 1 (the neighbour's input) captures and pin 0 does not.
- R7: With mode 11, every clock cycle in which trg_evt_i is high is one active event, with no edge detection, and pin activity captures nothing.
- R8: No capture occurs while the enable is 0 or while the mode code is 00.
- R9: Prescaler code 00/01/10/11 passes every 1st/2nd/4th/8th active event, and only passed events capture.
- R10: Clearing the enable resets the prescaler event count to zero.
- R11: A capture sets status bit 0. Writing 1 to status bit 0 clears it and writing 0 has no effect.
- R12: A capture while status bit 0 is set also sets status bit 1 (overcapture), which is cleared by writing 1 to status bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 3 | Asynchronous channel pins 0, 1, 2 |
| trg_evt_i | input | 1 | One-cycle trigger-controller event pulse |
| cnt_i | input | CNT_W | Free-running timer counter value |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register word address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data for bus_addr_i |

## Verification
The capture path is driven with single-pin edges of both polarities on each pin, with pin sequences whose XOR rises while single pins also change, and with trigger pulses one and two cycles long. These tell the own-pin, XOR and neighbour routes apart, and they separate edge detection from level counting. Each capture carries a distinct counter value, so the bench can see which event was latched. Runs of 1 to 8 trigger events under each prescaler code show where the division boundary falls. A run interrupted by an enable toggle shows whether the prescaler count was cleared. Configuration writes made with the channel enabled and disabled separate the locked mode field from the freely writable fields.

// File: rtl/tcf_pkg.sv
package tcf_pkg;
  typedef enum logic [1:0] {
    MODE_OUT = 2'b00,
    MODE_TI0 = 2'b01,
    MODE_TI1 = 2'b10,
    MODE_TRG = 2'b11
  } mode_e;

  localparam logic [1:0] ADDR_CFG = 2'd0;
  localparam logic [1:0] ADDR_CTL = 2'd1;
  localparam logic [1:0] ADDR_STS = 2'd2;
  localparam logic [1:0] ADDR_CAP = 2'd3;

  localparam int SRC_BIT = 31;
  localparam int PSC_LO  = 18;
  localparam int MODE_LO = 16;
  localparam int FILT_LO = 0;
endpackage

// File: rtl/tcf_sync.sv
module tcf_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/tcf_regs.sv
module tcf_regs
  import tcf_pkg::*;
#(
  parameter int PSC_W  = 2,
  parameter int FILT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [1:0]        bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic              src_xor_o,
  output logic [PSC_W-1:0]  psc_o,
  output mode_e             mode_o,
  output logic              en_o,
  output logic [1:0]        clr_o,
  output logic [31:0]       cfg_word_o,
  output logic [31:0]       ctl_word_o
);
  logic              src_q;
  logic [PSC_W-1:0]  psc_q;
  mode_e             mode_q;
  logic [FILT_W-1:0] filt_q;
  logic              en_q;

  logic wr_cfg, wr_ctl, wr_sts;
  assign wr_cfg = bus_we_i && (bus_addr_i == ADDR_CFG);
  assign wr_ctl = bus_we_i && (bus_addr_i == ADDR_CTL);
  assign wr_sts = bus_we_i && (bus_addr_i == ADDR_STS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= 1'b0;
      psc_q  <= '0;
      mode_q <= MODE_OUT;
      filt_q <= '0;
      en_q   <= 1'b0;
    end else begin
      if (wr_cfg) begin
        src_q  <= bus_wdata_i[SRC_BIT];
        psc_q  <= bus_wdata_i[PSC_LO +: PSC_W];
        filt_q <= bus_wdata_i[FILT_LO +: FILT_W];
        // mode field locked while the channel runs
        if (!en_q) mode_q <= mode_e'(bus_wdata_i[MODE_LO +: 2]);
      end
      if (wr_ctl) en_q <= bus_wdata_i[0];
    end
  end

  assign clr_o = wr_sts ? bus_wdata_i[1:0] : 2'b00;

  always_comb begin
    cfg_word_o                      = '0;
    cfg_word_o[SRC_BIT]             = src_q;
    cfg_word_o[PSC_LO +: PSC_W]     = psc_q;
    cfg_word_o[MODE_LO +: 2]        = mode_q;
    cfg_word_o[FILT_LO +: FILT_W]   = filt_q;
    ctl_word_o                      = {31'd0, en_q};
  end

  assign src_xor_o = src_q;
  assign psc_o     = psc_q;
  assign mode_o    = mode_q;
  assign en_o      = en_q;
endmodule

// File: rtl/tcf_evt.sv
module tcf_evt
  import tcf_pkg::*;
#(
  parameter int PSC_W = 2,
  localparam int PCW  = (1 << PSC_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       pin_s_i,
  input  logic             trg_i,
  input  logic             src_xor_i,
  input  mode_e            mode_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic             en_i,
  output logic             pass_o,
  output logic [PCW-1:0]   psc_cnt_o
);
  logic ti0, ti1, sel, sel_q, edge_evt, evt, active;
  logic [PCW-1:0] cnt_q, limit;

  assign ti0 = src_xor_i ? ^pin_s_i : pin_s_i[0];
  assign ti1 = pin_s_i[1];
  assign sel = (mode_i == MODE_TI1) ? ti1 : ti0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= 1'b0;
    else         sel_q <= sel;
  end

  assign edge_evt = sel & ~sel_q;
  assign evt      = (mode_i == MODE_TRG) ? trg_i : edge_evt;
  assign active   = en_i && (mode_i != MODE_OUT) && evt;
  assign limit    = PCW'((1 << psc_i) - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (active)  cnt_q <= (cnt_q >= limit) ? '0 : cnt_q + 1'b1;
  end

  assign pass_o    = active && (cnt_q >= limit);
  assign psc_cnt_o = cnt_q;
endmodule

// File: rtl/tcf_capture.sv
module tcf_capture #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pass_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [1:0]       clr_i,
  output logic [CNT_W-1:0] cap_o,
  output logic             flag_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cap_q;
  logic flag_q, ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (pass_i) cap_q <= cnt_i;
      // a new capture wins over a same-cycle clear
      if (pass_i)        flag_q <= 1'b1;
      else if (clr_i[0]) flag_q <= 1'b0;
      if (pass_i && flag_q) ovf_q <= 1'b1;
      else if (clr_i[1])    ovf_q <= 1'b0;
    end
  end

  assign cap_o  = cap_q;
  assign flag_o = flag_q;
  assign ovf_o  = ovf_q;
endmodule

// File: rtl/tcf_top.sv
module tcf_top
  import tcf_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int PSC_W       = 2,
  parameter int FILT_W      = 4,
  localparam int PCW        = (1 << PSC_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       pin_i,
  input  logic             trg_evt_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             bus_we_i,
  input  logic [1:0]       bus_addr_i,
  input  logic [31:0]      bus_wdata_i,
  output logic [31:0]      bus_rdata_o
);
  logic [2:0]       pin_s;
  logic             src_xor, en_q, pass;
  logic [PSC_W-1:0] psc_q;
  mode_e            mode_q;
  logic [1:0]       clr;
  logic [31:0]      cfg_word, ctl_word;
  logic [PCW-1:0]   psc_cnt_q;
  logic [CNT_W-1:0] cap_q;
  logic             flag_q, ovf_q;

  tcf_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(pin_s)
  );

  tcf_regs #(.PSC_W(PSC_W), .FILT_W(FILT_W)) u_regs (
    .clk_i, .rst_ni, .bus_we_i, .bus_addr_i, .bus_wdata_i,
    .src_xor_o(src_xor), .psc_o(psc_q), .mode_o(mode_q), .en_o(en_q),
    .clr_o(clr), .cfg_word_o(cfg_word), .ctl_word_o(ctl_word)
  );

  tcf_evt #(.PSC_W(PSC_W)) u_evt (
    .clk_i, .rst_ni, .pin_s_i(pin_s), .trg_i(trg_evt_i),
    .src_xor_i(src_xor), .mode_i(mode_q), .psc_i(psc_q), .en_i(en_q),
    .pass_o(pass), .psc_cnt_o(psc_cnt_q)
  );

  tcf_capture #(.CNT_W(CNT_W)) u_cap (
    .clk_i, .rst_ni, .pass_i(pass), .cnt_i, .clr_i(clr),
    .cap_o(cap_q), .flag_o(flag_q), .ovf_o(ovf_q)
  );

  always_comb begin
    unique case (bus_addr_i)
      ADDR_CFG: bus_rdata_o = cfg_word;
      ADDR_CTL: bus_rdata_o = ctl_word;
      ADDR_STS: bus_rdata_o = {30'd0, ovf_q, flag_q};
      default:  bus_rdata_o = 32'(cap_q);
    endcase
  end
endmodule

// File: rtl/tcf_chk.sv
module tcf_chk #(
  parameter int CNT_W = 16,
  parameter int PCW   = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_q,
  input logic [1:0]       mode_q,
  input logic [PCW-1:0]   psc_cnt_q,
  input logic [CNT_W-1:0] cap_q,
  input logic             flag_q,
  input logic             ovf_q
);
  a_r3_mode_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> $stable(mode_q));

  a_r8_no_cap_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q || mode_q == 2'b00) |=> $stable(cap_q));

  a_r10_psc_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> (psc_cnt_q == '0));

  a_r11_flag_on_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cap_q) |-> flag_q);

  a_r12_ovf_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_q) |-> $past(flag_q));
endmodule

bind tcf_top tcf_chk #(.CNT_W(CNT_W), .PCW(PCW)) u_chk (
  .clk_i, .rst_ni, .en_q, .mode_q, .psc_cnt_q, .cap_q, .flag_q, .ovf_q
);

// File: tb/sim_tcf_top.sv
module sim_tcf_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  pins = 3'b000;
  logic        trg = 1'b0;
  logic [15:0] cnt = 16'h0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rdata;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tcf_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pins), .trg_evt_i(trg), .cnt_i(cnt),
    .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic rd_chk(string req, logic [1:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic set_pins(logic [2:0] p, logic [15:0] c);
    @(negedge clk); cnt = c; pins = p;
    repeat (4) @(posedge clk);
  endtask

  task automatic pulse(int len, logic [15:0] c);
    @(negedge clk); cnt = c; trg = 1'b1;
    repeat (len) @(negedge clk);
    trg = 1'b0;
    @(negedge clk);
  endtask

  // channel off, pins idle, then new config and enable
  task automatic setup(logic [31:0] cfg);
    wr(2'd1, 32'd0);
    set_pins(3'b000, 16'h0);
    wr(2'd0, cfg);
    wr(2'd2, 32'd3);
    wr(2'd1, 32'd1);
  endtask

  task automatic t_reset;
    rd_chk("R1 cfg", 2'd0, 32'h0);
    rd_chk("R1 ctl", 2'd1, 32'h0);
    rd_chk("R1 sts", 2'd2, 32'h0);
    rd_chk("R1 cap", 2'd3, 32'h0);
  endtask

  task automatic t_fields;
    wr(2'd0, 32'hFFFF_FFFF);
    rd_chk("R2 all ones", 2'd0, 32'h800F_000F);
    wr(2'd0, 32'h0);
    rd_chk("R2 zero", 2'd0, 32'h0);
  endtask

  task automatic t_lock;
    wr(2'd0, 32'h0001_0000);
    wr(2'd1, 32'd1);
    wr(2'd0, 32'h800B_0005);
    rd_chk("R3 locked", 2'd0, 32'h8009_0005);
    wr(2'd1, 32'd0);
    wr(2'd0, 32'h800B_0005);
    rd_chk("R3 unlocked", 2'd0, 32'h800B_0005);
  endtask

  task automatic t_src_pin;
    setup(32'h0001_0000);
    set_pins(3'b100, 16'h1111);
    set_pins(3'b110, 16'h1112);
    rd_chk("R4 other pins", 2'd2, 32'h0);
    set_pins(3'b111, 16'h2222);
    rd_chk("R4 pin0 rise cap", 2'd3, 32'h2222);
    rd_chk("R11 flag set", 2'd2, 32'h1);
    set_pins(3'b110, 16'h3333);
    rd_chk("R4 fall ignored", 2'd3, 32'h2222);
  endtask

  task automatic t_src_xor;
    setup(32'h8001_0000);
    set_pins(3'b001, 16'h0A01);
    rd_chk("R5 xor rise 1", 2'd3, 32'h0A01);
    set_pins(3'b011, 16'h0A02);
    rd_chk("R5 xor fall", 2'd3, 32'h0A01);
    set_pins(3'b111, 16'h0A03);
    rd_chk("R5 xor rise 2", 2'd3, 32'h0A03);
  endtask

  task automatic t_neighbour;
    setup(32'h0002_0000);
    set_pins(3'b001, 16'h0B01);
    rd_chk("R6 pin0 ignored", 2'd2, 32'h0);
    set_pins(3'b011, 16'h0B02);
    rd_chk("R6 pin1 cap", 2'd3, 32'h0B02);
  endtask

  task automatic t_trigger;
    setup(32'h0007_0000);  // mode 11, every 2nd event
    set_pins(3'b111, 16'h0C00);
    rd_chk("R7 pins ignored", 2'd2, 32'h0);
    pulse(2, 16'h0C01);
    rd_chk("R7 two-cycle pulse", 2'd3, 32'h0C01);
    pulse(1, 16'h0C02);
    rd_chk("R7 odd event held", 2'd3, 32'h0C01);
    pulse(1, 16'h0C03);
    rd_chk("R7 even event cap", 2'd3, 32'h0C03);
  endtask

  task automatic t_off;
    wr(2'd1, 32'd0);
    set_pins(3'b000, 16'h0);
    wr(2'd0, 32'h0001_0000);
    wr(2'd2, 32'd3);
    set_pins(3'b001, 16'h0D01);
    rd_chk("R8 disabled", 2'd2, 32'h0);
    setup(32'h0000_0000);
    set_pins(3'b001, 16'h0D02);
    pulse(1, 16'h0D03);
    rd_chk("R8 mode 00", 2'd2, 32'h0);
  endtask

  task automatic t_prescale;
    for (int k = 0; k < 4; k++) begin
      int n = 1 << k;
      setup(32'h0003_0000 | (32'(k) << 18));
      for (int i = 1; i < n; i++) pulse(1, 16'(16'h100 * k + i));
      rd_chk($sformatf("R9 code %0d before", k), 2'd2, 32'h0);
      pulse(1, 16'(16'h100 * k + 16'h50));
      rd_chk($sformatf("R9 code %0d cap", k), 2'd3, 32'(16'h100 * k + 16'h50));
    end
  endtask

  task automatic t_psc_clear;
    setup(32'h000F_0000);
    for (int i = 0; i < 5; i++) pulse(1, 16'h0E00);
    wr(2'd1, 32'd0);
    wr(2'd1, 32'd1);
    for (int i = 0; i < 7; i++) pulse(1, 16'h0E01);
    rd_chk("R10 count restarted", 2'd2, 32'h0);
    pulse(1, 16'h0E08);
    rd_chk("R10 eighth cap", 2'd3, 32'h0E08);
  endtask

  task automatic t_flags;
    setup(32'h0003_0000);
    pulse(1, 16'h0F01);
    rd_chk("R11 flag only", 2'd2, 32'h1);
    wr(2'd2, 32'd0);
    rd_chk("R11 write 0 no effect", 2'd2, 32'h1);
    pulse(1, 16'h0F02);
    rd_chk("R12 overcapture", 2'd2, 32'h3);
    wr(2'd2, 32'd1);
    rd_chk("R11 w1c flag", 2'd2, 32'h2);
    wr(2'd2, 32'd2);
    rd_chk("R12 w1c ovf", 2'd2, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_fields;
    t_lock;
    t_src_pin;
    t_src_xor;
    t_neighbour;
    t_trigger;
    t_off;
    t_prescale;
    t_psc_clear;
    t_flags;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule